// File: doc/BRIEF.md
# CAN Controller Low-Power Mode Manager

This block decides when a CAN protocol controller may run, when it is frozen for debug, and when its clocks are shut off for low-power stop. It holds the host-writable mode bits: halt, stop, self-wake enable, wake-interrupt mask, soft reset, and a write-one-to-clear for the wake flag. It watches an external freeze line, the protocol engine's bus indications and a busy flag from the core. From these it drives a clock enable for the core, acknowledge and not-ready status, a forced-recessive transmit control, a wake flag and a wake interrupt.

Freeze is granted only once the core reports no activity. Stop is granted in two steps. The block first waits for a quiet point on the bus, then waits for the core to go idle. While stopped, the receive pin still goes through a free-running synchroniser, so a dominant edge can be seen with the core clock gated off. The edge can raise a wake flag and, if enabled, restart the controller. Any exit that loses bus synchronisation passes through a resynchronisation phase. That phase ends after a run of consecutive recessive bits, and only then may the controller join bus traffic.

Top module: `canlp_mode_mgr`

## Requirements
- R1: After `rst_n` is asserted, the block is in resynchronisation: `core_clk_en`=1, `not_ready`=1, `tx_force_rec`=1, `bus_join`=0, `frz_ack`=0, `stop_ack`=0, `ctl_stop`=0, `wake_flag`=0 and `wake_irq`=0.
- R2: In resynchronisation, every cycle with `bit_vld`=1 is one sampled bit, and `bit_val`=1 means recessive. `bus_join` goes to 1, and `not_ready` and `tx_force_rec` go to 0, on the clock edge that samples the 11th consecutive recessive bit. A dominant bit restarts the count from zero.
- R3: Freeze is requested by the halt bit or by `freeze_in`. `frz_ack` rises only on an edge where `core_busy` is 0. While waiting, `frz_ack`=0 and `bus_join`=0. While frozen, `frz_ack`=1, `not_ready`=1, `tx_force_rec`=1 and `core_clk_en`=1.
- R4: Freeze lasts as long as either the halt bit or `freeze_in` is 1. When both are 0, the block enters resynchronisation (R2), and `frz_ack` drops to 0.
- R5: A set stop bit is first held until `bus_idle`=1, or until an edge with `bit_vld`=1, `bit_val`=1 and `intm_idx`=3. Here `intm_idx` is 0 outside intermission and 1..3 for the intermission bit number. After that, the block waits for `core_busy`=0. Until then, `stop_ack`=0 and `core_clk_en`=1.
- R6: While stopped, `core_clk_en`=0, `stop_ack`=1, `not_ready`=1 and `tx_force_rec`=1.
- R7: When the host clears the stop bit while stopped, the block enters resynchronisation. Without self-wake armed, a receive edge leaves the block stopped.
- R8: Self-wake is armed only if the self-wake bit is 1 on the edge that enters stop. When armed, a recessive-to-dominant edge on `rx_pin` appears at the outputs three edges after the pin changes, because the pin passes through a two-flop synchroniser. On that edge `ctl_stop` goes to 0, `core_clk_en`=1 and `bus_join`=1 with no resynchronisation, and `sof_no_arb` is 1 for exactly one cycle.
- R9: Every recessive-to-dominant `rx_pin` edge seen while stopped sets `wake_flag`. A dominant-to-recessive edge does not set it. `wake_irq` is 1 only when `wake_flag` and the wake mask bit are both 1.
- R10: A host write with `wr_wakeclr`=1 clears `wake_flag`. A wake edge in the same cycle wins, and the flag stays 1.
- R11: A host write with `wr_softrst`=1 returns the block to the R1 state from any state, including stop, and ignores the other write fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_wr | input | 1 | Host write strobe for the mode bits |
| wr_halt | input | 1 | Halt bit value to write |
| wr_stop | input | 1 | Stop bit value to write |
| wr_selfwake | input | 1 | Self-wake enable value to write |
| wr_wakemsk | input | 1 | Wake interrupt mask value to write |
| wr_softrst | input | 1 | Soft reset request (1 = reset) |
| wr_wakeclr | input | 1 | Write one to clear the wake flag |
| freeze_in | input | 1 | External freeze request |
| bus_idle | input | 1 | Protocol engine reports an idle bus |
| bit_vld | input | 1 | One sampled bus bit this cycle |
| bit_val | input | 1 | Sampled bit, 1 = recessive |
| intm_idx | input | 2 | Intermission bit number, 0 = not in intermission |
| core_busy | input | 1 | Internal non-bus-interface activity pending |
| rx_pin | input | 1 | Raw receive line, asynchronous |
| core_clk_en | output | 1 | Clock enable for the controller core |
| frz_ack | output | 1 | Freeze acknowledge |
| stop_ack | output | 1 | Stop acknowledge |
| not_ready | output | 1 | Controller not synchronised to the bus |
| tx_force_rec | output | 1 | Force the transmit line recessive |
| ctl_stop | output | 1 | Current stop bit, for host readback |
| wake_flag | output | 1 | Wake status flag |
| wake_irq | output | 1 | Wake interrupt |
| bus_join | output | 1 | Controller may take part in bus traffic |
| sof_no_arb | output | 1 | Wake edge is to be taken as start-of-frame, without arbitration |

## Verification
Resynchronisation is driven with a recessive run broken by one dominant bit. This shows that the count restarts instead of accumulating. Stop entry is given intermission bits at index 2 and at index 3 with a dominant value, and only index 3 with a recessive value releases it. A held busy flag then separates the bus-quiet step from the core-idle step. Wake edges are applied with the mask on and off, with self-wake armed at entry and enabled only after entry, and with a flag-clear write in the same cycle. These cases separate the flag, the interrupt, the restart and the clear priority.

// File: rtl/canlp_pkg.sv
package canlp_pkg;

  typedef enum logic [2:0] {
    ST_RESYNC   = 3'd0,
    ST_RUN      = 3'd1,
    ST_FRZ_WAIT = 3'd2,
    ST_FROZEN   = 3'd3,
    ST_STP_BUS  = 3'd4,
    ST_STP_CORE = 3'd5,
    ST_STOPPED  = 3'd6
  } canlp_state_e;

  localparam logic RX_RECESSIVE = 1'b1;

endpackage

// File: rtl/canlp_rx_sync.sv
module canlp_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic fall_edge
);
  import canlp_pkg::*;

  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], rx_async};
  end

  // Free-running: never gated, so edges are seen while the core sleeps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {CHAIN_W{RX_RECESSIVE}};
    else        chain_q <= chain_d;
  end

  assign fall_edge = (chain_q[CHAIN_W-1] == RX_RECESSIVE) &&
                     (chain_q[CHAIN_W-2] != RX_RECESSIVE);

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_edge |=> !fall_edge); // R9

endmodule

// File: rtl/canlp_resync_cnt.sv
module canlp_resync_cnt #(
  parameter int NBITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_rec,
  output logic done
);

  localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (bit_vld) begin
      if (!bit_rec)           cnt_d = '0;
      else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = !clr && bit_vld && bit_rec && (cnt_q == LAST);

  AST_CNT_ONLY_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(bit_vld && bit_rec && !clr)); // R2

endmodule

// File: rtl/canlp_ctl_regs.sv
module canlp_ctl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_wr,
  input  logic wr_halt,
  input  logic wr_stop,
  input  logic wr_selfwake,
  input  logic wr_wakemsk,
  input  logic wr_softrst,
  input  logic wr_wakeclr,
  input  logic self_wake,
  input  logic wake_evt,
  output logic soft_rst,
  output logic halt_q,
  output logic stop_q,
  output logic selfwake_q,
  output logic wakemsk_q,
  output logic wake_flag_q
);

  logic halt_d, stop_d, selfwake_d, wakemsk_d, wake_flag_d;
  logic wr_cfg;

  assign soft_rst = reg_wr && wr_softrst;
  assign wr_cfg   = reg_wr && !wr_softrst;

  always_comb begin
    halt_d      = halt_q;
    stop_d      = stop_q;
    selfwake_d  = selfwake_q;
    wakemsk_d   = wakemsk_q;
    wake_flag_d = wake_flag_q;
    if (soft_rst) begin
      halt_d      = 1'b0;
      stop_d      = 1'b0;
      selfwake_d  = 1'b0;
      wakemsk_d   = 1'b0;
      wake_flag_d = 1'b0;
    end else begin
      if (wr_cfg) begin
        halt_d     = wr_halt;
        stop_d     = wr_stop;
        selfwake_d = wr_selfwake;
        wakemsk_d  = wr_wakemsk;
      end
      // Self-wake beats a simultaneous host write of the stop bit.
      if (self_wake) stop_d = 1'b0;
      // A new wake event beats a simultaneous clear.
      if (wake_evt)                  wake_flag_d = 1'b1;
      else if (wr_cfg && wr_wakeclr) wake_flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q      <= 1'b0;
      stop_q      <= 1'b0;
      selfwake_q  <= 1'b0;
      wakemsk_q   <= 1'b0;
      wake_flag_q <= 1'b0;
    end else begin
      halt_q      <= halt_d;
      stop_q      <= stop_d;
      selfwake_q  <= selfwake_d;
      wakemsk_q   <= wakemsk_d;
      wake_flag_q <= wake_flag_d;
    end
  end

  AST_FLAG_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag_q) |-> $past(wake_evt)); // R9

  AST_EVENT_WINS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !soft_rst) |=> wake_flag_q); // R10

  AST_SRST_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !stop_q); // R11

endmodule

// File: rtl/canlp_mode_fsm.sv
module canlp_mode_fsm #(
  parameter int INTM_W        = 2,
  parameter int INTM_STOP_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              frz_req,
  input  logic              stop_bit,
  input  logic              selfwake_bit,
  input  logic              bus_idle,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic [INTM_W-1:0] intm_idx,
  input  logic              core_busy,
  input  logic              wake_edge,
  input  logic              resync_done,
  output canlp_pkg::canlp_state_e state,
  output logic              self_wake,
  output logic              wake_evt,
  output logic              sof_pulse
);
  import canlp_pkg::*;

  localparam logic [INTM_W-1:0] STOP_IDX = INTM_W'(INTM_STOP_IDX);

  canlp_state_e st_q, st_d;
  logic armed_q, armed_d;
  logic sof_q, sof_d;
  logic quiet_pt;

  assign quiet_pt  = bus_idle || (bit_vld && bit_val && (intm_idx == STOP_IDX));
  assign wake_evt  = (st_q == ST_STOPPED) && wake_edge;
  assign self_wake = wake_evt && armed_q && !soft_rst;

  always_comb begin
    st_d = st_q;
    if (soft_rst) begin
      st_d = ST_RESYNC;
    end else begin
      case (st_q)
        ST_RESYNC: begin
          if (frz_req)          st_d = ST_FRZ_WAIT;
          else if (stop_bit)    st_d = ST_STP_BUS;
          else if (resync_done) st_d = ST_RUN;
        end
        ST_RUN: begin
          if (frz_req)       st_d = ST_FRZ_WAIT;
          else if (stop_bit) st_d = ST_STP_BUS;
        end
        ST_FRZ_WAIT: begin
          if (!frz_req)        st_d = ST_RESYNC;
          else if (!core_busy) st_d = ST_FROZEN;
        end
        ST_FROZEN: begin
          if (!frz_req) st_d = ST_RESYNC;
        end
        ST_STP_BUS: begin
          if (!stop_bit)     st_d = ST_RESYNC;
          else if (quiet_pt) st_d = ST_STP_CORE;
        end
        ST_STP_CORE: begin
          if (!stop_bit)       st_d = ST_RESYNC;
          else if (!core_busy) st_d = ST_STOPPED;
        end
        ST_STOPPED: begin
          if (self_wake)     st_d = ST_RUN;
          else if (!stop_bit) st_d = ST_RESYNC;
        end
        default: st_d = ST_RESYNC;
      endcase
    end
  end

  always_comb begin
    if (st_d != ST_STOPPED)      armed_d = 1'b0;
    else if (st_q == ST_STOPPED) armed_d = armed_q;
    else                         armed_d = selfwake_bit;
    sof_d = self_wake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RESYNC;
      armed_q <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      sof_q   <= sof_d;
    end
  end

  assign state     = st_q;
  assign sof_pulse = sof_q;

  AST_FREEZE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FROZEN && $past(st_q) != ST_FROZEN) |-> $past(!core_busy && frz_req)); // R3

  AST_STOP_QUIET_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STP_CORE && $past(st_q) == ST_STP_BUS) |-> $past(quiet_pt)); // R5

  AST_STOP_CORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOPPED && $past(st_q) != ST_STOPPED) |-> $past(!core_busy)); // R5

  AST_SOF_AFTER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> $past(st_q == ST_STOPPED && armed_q)); // R8

  AST_SOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |=> !sof_q); // R8

endmodule

// File: rtl/canlp_mode_mgr.sv
module canlp_mode_mgr #(
  parameter int RESYNC_BITS   = 11,
  parameter int SYNC_STAGES   = 2,
  parameter int INTM_W        = 2,
  parameter int INTM_STOP_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              wr_halt,
  input  logic              wr_stop,
  input  logic              wr_selfwake,
  input  logic              wr_wakemsk,
  input  logic              wr_softrst,
  input  logic              wr_wakeclr,
  input  logic              freeze_in,
  input  logic              bus_idle,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic [INTM_W-1:0] intm_idx,
  input  logic              core_busy,
  input  logic              rx_pin,
  output logic              core_clk_en,
  output logic              frz_ack,
  output logic              stop_ack,
  output logic              not_ready,
  output logic              tx_force_rec,
  output logic              ctl_stop,
  output logic              wake_flag,
  output logic              wake_irq,
  output logic              bus_join,
  output logic              sof_no_arb
);
  import canlp_pkg::*;

  canlp_state_e state;
  logic soft_rst, halt_q, stop_q, selfwake_q, wakemsk_q, wake_flag_q;
  logic wake_edge, resync_done, self_wake, wake_evt, sof_pulse;
  logic frz_req, off_bus;

  assign frz_req = halt_q || freeze_in;

  canlp_rx_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_async  (rx_pin),
    .fall_edge (wake_edge)
  );

  canlp_resync_cnt #(.NBITS(RESYNC_BITS)) u_resync (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state != ST_RESYNC),
    .bit_vld (bit_vld),
    .bit_rec (bit_val),
    .done    (resync_done)
  );

  canlp_ctl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .wr_halt     (wr_halt),
    .wr_stop     (wr_stop),
    .wr_selfwake (wr_selfwake),
    .wr_wakemsk  (wr_wakemsk),
    .wr_softrst  (wr_softrst),
    .wr_wakeclr  (wr_wakeclr),
    .self_wake   (self_wake),
    .wake_evt    (wake_evt),
    .soft_rst    (soft_rst),
    .halt_q      (halt_q),
    .stop_q      (stop_q),
    .selfwake_q  (selfwake_q),
    .wakemsk_q   (wakemsk_q),
    .wake_flag_q (wake_flag_q)
  );

  canlp_mode_fsm #(.INTM_W(INTM_W), .INTM_STOP_IDX(INTM_STOP_IDX)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .frz_req      (frz_req),
    .stop_bit     (stop_q),
    .selfwake_bit (selfwake_q),
    .bus_idle     (bus_idle),
    .bit_vld      (bit_vld),
    .bit_val      (bit_val),
    .intm_idx     (intm_idx),
    .core_busy    (core_busy),
    .wake_edge    (wake_edge),
    .resync_done  (resync_done),
    .state        (state),
    .self_wake    (self_wake),
    .wake_evt     (wake_evt),
    .sof_pulse    (sof_pulse)
  );

  assign off_bus      = (state == ST_RESYNC) || (state == ST_FROZEN) ||
                        (state == ST_STOPPED);
  assign core_clk_en  = (state != ST_STOPPED);
  assign frz_ack      = (state == ST_FROZEN);
  assign stop_ack     = (state == ST_STOPPED);
  assign not_ready    = off_bus;
  assign tx_force_rec = off_bus;
  assign bus_join     = (state == ST_RUN);
  assign ctl_stop     = stop_q;
  assign wake_flag    = wake_flag_q;
  assign wake_irq     = wake_flag_q && wakemsk_q;
  assign sof_no_arb   = sof_pulse;

  AST_STOP_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> (!core_clk_en && !bus_join)); // R6

  AST_STOPPED_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_ack)) |-> ctl_stop); // R5

  AST_JOIN_AFTER_WAKE_OR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_join) |-> ($past(resync_done) || sof_no_arb)); // R2

endmodule

// File: tb/canlp_mode_mgr_bench.sv
`timescale 1ns/1ps
module canlp_mode_mgr_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, wr_halt, wr_stop, wr_selfwake, wr_wakemsk, wr_softrst, wr_wakeclr;
  logic freeze_in, bus_idle, bit_vld, bit_val, core_busy, rx_pin;
  logic [1:0] intm_idx;
  logic core_clk_en, frz_ack, stop_ack, not_ready, tx_force_rec;
  logic ctl_stop, wake_flag, wake_irq, bus_join, sof_no_arb;

  always #2.5 clk = ~clk;

  canlp_mode_mgr u_canlp_mode_mgr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_halt(wr_halt), .wr_stop(wr_stop),
    .wr_selfwake(wr_selfwake), .wr_wakemsk(wr_wakemsk), .wr_softrst(wr_softrst),
    .wr_wakeclr(wr_wakeclr), .freeze_in(freeze_in), .bus_idle(bus_idle),
    .bit_vld(bit_vld), .bit_val(bit_val), .intm_idx(intm_idx), .core_busy(core_busy),
    .rx_pin(rx_pin), .core_clk_en(core_clk_en), .frz_ack(frz_ack), .stop_ack(stop_ack),
    .not_ready(not_ready), .tx_force_rec(tx_force_rec), .ctl_stop(ctl_stop),
    .wake_flag(wake_flag), .wake_irq(wake_irq), .bus_join(bus_join), .sof_no_arb(sof_no_arb)
  );

  localparam int O_CLK = 0, O_FRZ = 1, O_STP = 2, O_NRDY = 3, O_TXR = 4,
                 O_CSTOP = 5, O_WFLG = 6, O_WIRQ = 7, O_JOIN = 8, O_SOF = 9;

  typedef struct {
    string req;
    string what;
    int    sel;
    int    exp;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic int observe(int sel);
    case (sel)
      O_CLK:   return int'(core_clk_en);
      O_FRZ:   return int'(frz_ack);
      O_STP:   return int'(stop_ack);
      O_NRDY:  return int'(not_ready);
      O_TXR:   return int'(tx_force_rec);
      O_CSTOP: return int'(ctl_stop);
      O_WFLG:  return int'(wake_flag);
      O_WIRQ:  return int'(wake_irq);
      O_JOIN:  return int'(bus_join);
      default: return int'(sof_no_arb);
    endcase
  endfunction

  // Monitor: pops expectations and compares them away from the active edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_item_t it;
      int act;
      it  = sb_q.pop_front();
      act = observe(it.sel);
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s %s: actual %0d expected %0d at %0t", it.req, it.what, act, it.exp, $time);
      end
    end
  end

  task automatic push(string r, string w, int sel, int e);
    exp_item_t it;
    it.req = r; it.what = w; it.sel = sel; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic host_write(logic h, logic s, logic sw, logic m, logic sr, logic wc);
    reg_wr = 1'b1; wr_halt = h; wr_stop = s; wr_selfwake = sw;
    wr_wakemsk = m; wr_softrst = sr; wr_wakeclr = wc;
    tick();
    reg_wr = 1'b0; wr_halt = 1'b0; wr_stop = 1'b0; wr_selfwake = 1'b0;
    wr_wakemsk = 1'b0; wr_softrst = 1'b0; wr_wakeclr = 1'b0;
  endtask

  task automatic resync_run(string r);
    bit_vld = 1'b1; bit_val = 1'b1;
    ticks(10);
    push(r, "join before 11th", O_JOIN, 0);
    tick();
    push(r, "join at 11th", O_JOIN, 1);
    push(r, "not_ready at 11th", O_NRDY, 0);
    bit_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; wr_halt = 1'b0; wr_stop = 1'b0; wr_selfwake = 1'b0;
    wr_wakemsk = 1'b0; wr_softrst = 1'b0; wr_wakeclr = 1'b0; freeze_in = 1'b0;
    bus_idle = 1'b1; bit_vld = 1'b0; bit_val = 1'b1; intm_idx = 2'd0;
    core_busy = 1'b0; rx_pin = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    push("R1", "clk_en", O_CLK, 1);   push("R1", "not_ready", O_NRDY, 1);
    push("R1", "tx_rec", O_TXR, 1);   push("R1", "join", O_JOIN, 0);
    push("R1", "frz_ack", O_FRZ, 0);  push("R1", "stop_ack", O_STP, 0);
    push("R1", "ctl_stop", O_CSTOP, 0); push("R1", "wake_flag", O_WFLG, 0);
    push("R1", "wake_irq", O_WIRQ, 0);
    tick();

    // R2: recessive run broken by a dominant bit
    bit_vld = 1'b1; bit_val = 1'b1;
    ticks(5);
    bit_val = 1'b0; tick();
    push("R2", "join after broken run", O_JOIN, 0);
    resync_run("R2");
    push("R2", "tx_rec cleared", O_TXR, 0);

    // R3: freeze via line, held off by busy core
    core_busy = 1'b1; freeze_in = 1'b1;
    ticks(4);
    push("R3", "frz_ack while busy", O_FRZ, 0);
    push("R3", "join while waiting", O_JOIN, 0);
    core_busy = 1'b0; tick();
    push("R3", "frz_ack when idle", O_FRZ, 1);
    push("R3", "not_ready frozen", O_NRDY, 1);
    push("R3", "tx_rec frozen", O_TXR, 1);
    push("R3", "clk_en frozen", O_CLK, 1);

    // R4: halt keeps freeze after the line drops; clearing halt resyncs
    host_write(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    freeze_in = 1'b0; tick();
    push("R4", "frz_ack held by halt", O_FRZ, 1);
    host_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick();
    push("R4", "frz_ack after exit", O_FRZ, 0);
    push("R4", "not_ready after exit", O_NRDY, 1);
    resync_run("R4");

    // R5: stop waits for the third intermission bit, then for the core
    bus_idle = 1'b0;
    host_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(4);
    push("R5", "stop_ack while bus busy", O_STP, 0);
    push("R5", "clk_en while bus busy", O_CLK, 1);
    bit_vld = 1'b1; bit_val = 1'b1; intm_idx = 2'd2; tick();
    bit_val = 1'b0; intm_idx = 2'd3; tick();
    bit_vld = 1'b0; intm_idx = 2'd0; ticks(2);
    push("R5", "stop_ack after idx2/dominant idx3", O_STP, 0);
    core_busy = 1'b1;
    bit_vld = 1'b1; bit_val = 1'b1; intm_idx = 2'd3; tick();
    bit_vld = 1'b0; intm_idx = 2'd0; ticks(3);
    push("R5", "stop_ack while core busy", O_STP, 0);
    push("R5", "clk_en while core busy", O_CLK, 1);
    core_busy = 1'b0; tick();
    // R6 stopped outputs
    push("R6", "stop_ack", O_STP, 1);   push("R6", "clk_en", O_CLK, 0);
    push("R6", "not_ready", O_NRDY, 1); push("R6", "tx_rec", O_TXR, 1);
    push("R6", "ctl_stop", O_CSTOP, 1);
    bus_idle = 1'b1;

    // R9/R7: wake edge with mask on, self-wake not armed
    host_write(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    rx_pin = 1'b0; ticks(3);
    push("R9", "flag on edge", O_WFLG, 1);
    push("R9", "irq masked on", O_WIRQ, 1);
    push("R7", "still stopped", O_STP, 1);
    push("R7", "clk still off", O_CLK, 0);
    rx_pin = 1'b1; ticks(3);
    push("R9", "flag after rising", O_WFLG, 1);
    // R10 clear, then clear colliding with an edge
    host_write(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    push("R10", "flag cleared", O_WFLG, 0);
    push("R10", "irq cleared", O_WIRQ, 0);
    rx_pin = 1'b0; ticks(2);
    host_write(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    push("R10", "edge wins over clear", O_WFLG, 1);
    rx_pin = 1'b1; ticks(3);
    // R9 mask off
    host_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    rx_pin = 1'b0; ticks(3);
    push("R9", "flag with mask off", O_WFLG, 1);
    push("R9", "irq with mask off", O_WIRQ, 0);
    rx_pin = 1'b1; ticks(3);
    // R7 host clears stop
    host_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    push("R7", "ctl_stop cleared", O_CSTOP, 0);
    tick();
    push("R7", "stop_ack after clear", O_STP, 0);
    push("R7", "clk_en after clear", O_CLK, 1);
    push("R7", "not_ready after clear", O_NRDY, 1);
    resync_run("R7");

    // R8 self-wake armed at entry
    host_write(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    ticks(3);
    push("R8", "stopped before wake", O_STP, 1);
    push("R8", "flag clear before wake", O_WFLG, 0);
    rx_pin = 1'b0; ticks(2);
    push("R8", "still stopped in sync", O_STP, 1);
    tick();
    push("R8", "ctl_stop cleared", O_CSTOP, 0);
    push("R8", "clk_en restarted", O_CLK, 1);
    push("R8", "join without resync", O_JOIN, 1);
    push("R8", "sof pulse", O_SOF, 1);
    push("R9", "flag on self-wake", O_WFLG, 1);
    tick();
    push("R8", "sof one cycle", O_SOF, 0);
    rx_pin = 1'b1; ticks(3);

    // R8 self-wake enabled only after entry does not restart
    host_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    ticks(3);
    host_write(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    rx_pin = 1'b0; ticks(3);
    push("R8", "late enable stays stopped", O_STP, 1);
    push("R8", "late enable ctl_stop", O_CSTOP, 1);
    rx_pin = 1'b1; ticks(3);

    // R11 soft reset out of stop
    host_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    push("R11", "stop_ack", O_STP, 0);   push("R11", "ctl_stop", O_CSTOP, 0);
    push("R11", "clk_en", O_CLK, 1);     push("R11", "not_ready", O_NRDY, 1);
    push("R11", "join", O_JOIN, 0);      push("R11", "wake_flag", O_WFLG, 0);

    ticks(2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule